// File: doc/BRIEF.md
# Banked Endpoint Register Window

This block keeps the per-endpoint control and status registers of a seven-endpoint USB device controller. It shows them to the processor through a window of four registers. One window register is an endpoint selector. The other three (configuration, status, byte count) reach the bank that the selector names. Each endpoint therefore costs no extra processor address space, and software works on one endpoint at a time by first writing its number.

The packet engine has a second port, with its own endpoint index. Through it the engine sets status flags and loads byte counts in any bank, whatever the processor has selected. When both sides touch the same register in the same cycle, the engine's update takes effect. Endpoint 0 is the default control endpoint. Its configuration is fixed and cannot be changed.

Top module: `ep_reg_window`

## Requirements
- R1: After reset the selector reads 0. Every bank's status and byte count read 0. Endpoints 1 to 6 read configuration 0x00, and endpoint 0 reads configuration 0x80.
- R2: A processor write of a value from 0 to 6 to window address 0 makes that value the selected endpoint. Reading address 0 returns it. Addresses 1, 2 and 3 then reach that endpoint's configuration, status and byte count.
- R3: A processor write of a value above 6 to address 0 is ignored, and the previous selection stays in force.
- R4: For endpoints 1 to 6 the configuration register keeps bit 7 (enable), bit 2 (direction, 1 = IN) and bits 1:0 (type: 00 control, 01 isochronous, 10 bulk, 11 interrupt). All other bits read 0.
- R5: Processor writes to endpoint 0's configuration are ignored. It always reads 0x80 (enabled, OUT, type control).
- R6: The status register is 4 bits wide (bits 3:0; bits 7:4 read 0). A processor write clears each status bit whose write-data bit is 1 and leaves the other bits as they were.
- R7: The engine port sets the status bits given in its set mask, in the bank named by its endpoint index, whatever the processor has selected. If in the same cycle the processor clears a bit that the engine sets, the bit ends up 1.
- R8: The byte count is 7 bits wide (bit 7 reads 0). The processor loads it through address 3. The engine loads it with its count-write strobe, in the bank its index names. If both load the same bank in one cycle, the engine's value is kept.
- R9: Read data is registered. It appears in the cycle after the read strobe and shows the register as it was before any write in that same cycle. It holds until the next read.
- R10: A processor write through the window changes only the selected bank. Every other bank keeps its values.
- R11: An engine index above 6 changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_addr | input | 2 | Window address: 0 selector, 1 configuration, 2 status, 3 byte count |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered read data |
| sie_ep | input | 3 | Engine endpoint index |
| sie_stat_set | input | 4 | Engine status set mask |
| sie_cnt_we | input | 1 | Engine byte-count write strobe |
| sie_cnt | input | 7 | Engine byte-count value |

## Verification
The hardest cases to reach are two cases where both sides act in one cycle. In the first, a processor clear meets an engine set on the same status bit. In the second, processor and engine load the same byte count. The stimulus selects an endpoint and then drives the window write and the engine strobe in one clock, aimed at that bank. A follow-up read through the window shows which side's value stuck. Engine updates to a bank that is not selected are checked later by moving the selector to it. An out-of-range engine index is checked the same way, by reading every bank afterwards.

// File: rtl/ep_win_pkg.sv
package ep_win_pkg;
  parameter int NUM_EP = 7;
  parameter int DATA_W = 8;
  parameter int STAT_W = 4;
  parameter int CNT_W  = 7;
  parameter int ADDR_W = 2;
  localparam int IDX_W = $clog2(NUM_EP);

  typedef enum logic [ADDR_W-1:0] {
    WIN_SEL  = 2'd0,
    WIN_CFG  = 2'd1,
    WIN_STAT = 2'd2,
    WIN_CNT  = 2'd3
  } win_addr_e;

  typedef enum logic [1:0] {
    XFER_CTRL = 2'b00,
    XFER_ISO  = 2'b01,
    XFER_BULK = 2'b10,
    XFER_INTR = 2'b11
  } xfer_type_e;

  localparam int CFG_EN_BIT  = 7;
  localparam int CFG_DIR_BIT = 2;
endpackage

// File: rtl/ep_win_index.sv
module ep_win_index
  import ep_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  sel
);
  always_ff @(posedge clk) begin
    if (rst)
      sel <= '0;
    else if (wr_en && (int'(wdata) < NUM_EP))
      sel <= wdata[IDX_W-1:0];
  end

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(sel) < NUM_EP); // R2
  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wdata) >= NUM_EP) |=> $stable(sel)); // R3
endmodule

// File: rtl/ep_win_bank.sv
module ep_win_bank
  import ep_win_pkg::*;
#(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              st_clr_we,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sie_hit,
  input  logic [STAT_W-1:0] sie_set,
  input  logic              sie_cnt_we,
  input  logic [CNT_W-1:0]  sie_cnt,
  output logic [DATA_W-1:0] cfg,
  output logic [STAT_W-1:0] st,
  output logic [CNT_W-1:0]  cnt
);
  logic       en_q;
  logic       dir_q;
  logic [1:0] typ_q;

  generate
    if (IS_EP0) begin : g_fixed
      assign en_q  = 1'b1;
      assign dir_q = 1'b0;
      assign typ_q = XFER_CTRL;
    end else begin : g_prog
      always_ff @(posedge clk) begin
        if (rst) begin
          en_q  <= 1'b0;
          dir_q <= 1'b0;
          typ_q <= XFER_CTRL;
        end else if (cfg_we) begin
          en_q  <= wdata[CFG_EN_BIT];
          dir_q <= wdata[CFG_DIR_BIT];
          typ_q <= wdata[1:0];
        end
      end
    end
  endgenerate

  always_comb begin
    cfg              = '0;
    cfg[CFG_EN_BIT]  = en_q;
    cfg[CFG_DIR_BIT] = dir_q;
    cfg[1:0]         = typ_q;
  end

  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] set_mask;
  assign clr_mask = st_clr_we ? wdata[STAT_W-1:0] : '0;
  assign set_mask = sie_hit ? sie_set : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= '0;
      cnt <= '0;
    end else begin
      st <= (st & ~clr_mask) | set_mask;
      if (sie_hit && sie_cnt_we)
        cnt <= sie_cnt;
      else if (cnt_we)
        cnt <= wdata[CNT_W-1:0];
    end
  end

  AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
    sie_hit |=> ((st & $past(sie_set)) == $past(sie_set))); // R7
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (st_clr_we && !sie_hit) |=> ((st & $past(wdata[STAT_W-1:0])) == '0)); // R6
  AST_CNT_SIE_WINS: assert property (@(posedge clk) disable iff (rst)
    (sie_hit && sie_cnt_we) |=> (cnt == $past(sie_cnt))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !st_clr_we && !cnt_we && !sie_hit) |=> ($stable(st) && $stable(cnt) && $stable(cfg))); // R10
endmodule

// File: rtl/ep_win_rdmux.sv
module ep_win_rdmux
  import ep_win_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [IDX_W-1:0]              sel,
  input  logic [NUM_EP-1:0][DATA_W-1:0] cfg_a,
  input  logic [NUM_EP-1:0][STAT_W-1:0] st_a,
  input  logic [NUM_EP-1:0][CNT_W-1:0]  cnt_a,
  output logic [DATA_W-1:0]             rdata
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (win_addr_e'(addr))
      WIN_SEL:  rd_next[IDX_W-1:0]  = sel;
      WIN_CFG:  rd_next             = cfg_a[sel];
      WIN_STAT: rd_next[STAT_W-1:0] = st_a[sel];
      WIN_CNT:  rd_next[CNT_W-1:0]  = cnt_a[sel];
      default:  rd_next             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_next;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata)); // R9
endmodule

// File: rtl/ep_reg_window.sv
module ep_reg_window
  import ep_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [1:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic [2:0]        sie_ep,
  input  logic [3:0]        sie_stat_set,
  input  logic              sie_cnt_we,
  input  logic [6:0]        sie_cnt
);
  logic [IDX_W-1:0]              sel;
  logic [NUM_EP-1:0][DATA_W-1:0] cfg_a;
  logic [NUM_EP-1:0][STAT_W-1:0] st_a;
  logic [NUM_EP-1:0][CNT_W-1:0]  cnt_a;
  logic [NUM_EP-1:0]             bank_wr;

  ep_win_index u_index (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cpu_wr && (cpu_addr == WIN_SEL)),
    .wdata (cpu_wdata),
    .sel   (sel)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EP; gi++) begin : g_bank
      logic here;
      assign here        = (sel == IDX_W'(gi));
      assign bank_wr[gi] = cpu_wr && here && (cpu_addr != WIN_SEL);
      ep_win_bank #(.IS_EP0(gi == 0)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (bank_wr[gi] && (cpu_addr == WIN_CFG)),
        .st_clr_we  (bank_wr[gi] && (cpu_addr == WIN_STAT)),
        .cnt_we     (bank_wr[gi] && (cpu_addr == WIN_CNT)),
        .wdata      (cpu_wdata),
        .sie_hit    (sie_ep == IDX_W'(gi)),
        .sie_set    (sie_stat_set),
        .sie_cnt_we (sie_cnt_we),
        .sie_cnt    (sie_cnt),
        .cfg        (cfg_a[gi]),
        .st         (st_a[gi]),
        .cnt        (cnt_a[gi])
      );
    end
  endgenerate

  ep_win_rdmux u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd    (cpu_rd),
    .addr  (cpu_addr),
    .sel   (sel),
    .cfg_a (cfg_a),
    .st_a  (st_a),
    .cnt_a (cnt_a),
    .rdata (cpu_rdata)
  );

  AST_ONE_BANK_WR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_wr)); // R10
  AST_EP0_CFG: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == WIN_CFG && sel == '0) |=> (cpu_rdata == 8'h80)); // R5
endmodule

// File: tb/test_ep_reg_window.sv
module test_ep_reg_window;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [2:0] sie_ep = 3'd7;
  logic [3:0] sie_stat_set = '0;
  logic       sie_cnt_we = 1'b0;
  logic [6:0] sie_cnt = '0;

  ep_reg_window i_ep_reg_window (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sie_ep(sie_ep),
    .sie_stat_set(sie_stat_set), .sie_cnt_we(sie_cnt_we), .sie_cnt(sie_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_cfg [7];
  logic [3:0] m_st  [7];
  logic [6:0] m_cnt [7];
  int         m_sel;

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return 8'(m_sel);
      2'd1: return m_cfg[m_sel];
      2'd2: return {4'h0, m_st[m_sel]};
      default: return {1'b0, m_cnt[m_sel]};
    endcase
  endfunction

  // Monitor: compares read data one cycle after each read strobe
  logic pend = 1'b0;
  always @(posedge clk) pend <= cpu_rd && !rst;
  always @(negedge clk) begin
    if (pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (cpu_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", t, cpu_rdata, e);
      end
    end
  end

  // Driver: one cycle of stimulus, model updated with engine last (engine wins)
  task automatic step(input bit wr, input bit rd, input logic [1:0] a, input logic [7:0] d,
                      input logic [2:0] ep, input logic [3:0] set, input bit cwe,
                      input logic [6:0] c, input string tag);
    int s;
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    sie_ep = ep; sie_stat_set = set; sie_cnt_we = cwe; sie_cnt = c;
    if (rd) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    s = m_sel;
    if (wr) begin
      case (a)
        2'd0: if (d < 8'd7) m_sel = int'(d);
        2'd1: if (s != 0) m_cfg[s] = d & 8'h87;
        2'd2: m_st[s] = m_st[s] & ~d[3:0];
        default: m_cnt[s] = d[6:0];
      endcase
    end
    if (ep < 3'd7) begin
      m_st[ep] = m_st[ep] | set;
      if (cwe) m_cnt[ep] = c;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; sie_ep = 3'd7; sie_stat_set = '0; sie_cnt_we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 3'd7, 4'h0, 0, 7'h0, "");
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 1, a, 8'h0, 3'd7, 4'h0, 0, 7'h0, tag);
  endtask
  task automatic sie(input logic [2:0] ep, input logic [3:0] set, input bit cwe, input logic [6:0] c);
    step(0, 0, 2'd0, 8'h0, ep, set, cwe, c, "");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) begin
      m_cfg[i] = (i == 0) ? 8'h80 : 8'h00; m_st[i] = '0; m_cnt[i] = '0;
    end
    m_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state of selector and every bank
    rd(2'd0, "R1 selector");
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'(i));
      rd(2'd1, "R1 cfg");
      rd(2'd2, "R1 status");
      rd(2'd3, "R1 count");
    end

    // R2 / R3: selection and out-of-range selector writes
    wr(2'd0, 8'd3); rd(2'd0, "R2 select 3");
    wr(2'd0, 8'd9); rd(2'd0, "R3 write 9 ignored");
    wr(2'd0, 8'd7); rd(2'd0, "R3 write 7 ignored");

    // R4: programmable configuration fields
    wr(2'd1, 8'hFF); rd(2'd1, "R4 cfg ep3 masked");
    wr(2'd0, 8'd5); wr(2'd1, 8'h82); rd(2'd1, "R4 cfg ep5 bulk");
    wr(2'd0, 8'd6); wr(2'd1, 8'h07); rd(2'd1, "R4 cfg ep6 intr IN disabled");

    // R5: endpoint 0 configuration locked
    wr(2'd0, 8'd0); wr(2'd1, 8'h07); rd(2'd1, "R5 ep0 cfg fixed");

    // R7: engine sets status on unselected endpoint 4
    sie(3'd4, 4'hF, 0, 7'h0);
    rd(2'd2, "R7 ep0 status untouched");
    wr(2'd0, 8'd4); rd(2'd2, "R7 ep4 status set");
    // R6: write-one-to-clear
    wr(2'd2, 8'h05); rd(2'd2, "R6 w1c partial");
    // R7: engine set beats processor clear
    step(1, 0, 2'd2, 8'h0A, 3'd4, 4'h2, 0, 7'h0, "");
    rd(2'd2, "R7 set wins over clear");

    // R8: byte count paths and collision
    wr(2'd3, 8'hFF); rd(2'd3, "R8 cpu count 7 bit");
    wr(2'd3, 8'h33); rd(2'd3, "R8 cpu count");
    sie(3'd4, 4'h0, 1, 7'h40); rd(2'd3, "R8 engine count");
    step(1, 0, 2'd3, 8'h11, 3'd4, 4'h0, 1, 7'h22, "");
    rd(2'd3, "R8 engine wins count");
    sie(3'd2, 4'h0, 1, 7'h15);
    wr(2'd0, 8'd2); rd(2'd3, "R8 engine count unselected ep2");

    // R10: other banks untouched by ep4 window writes
    wr(2'd0, 8'd3); rd(2'd1, "R10 ep3 cfg kept"); rd(2'd3, "R10 ep3 count kept");
    wr(2'd0, 8'd5); rd(2'd2, "R10 ep5 status kept");

    // R11: engine index 7 reaches nothing
    sie(3'd7, 4'hF, 1, 7'h55);
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'(i));
      rd(2'd2, "R11 status after bad index");
      rd(2'd3, "R11 count after bad index");
    end

    // R9: read concurrent with write returns old value, then new
    step(1, 1, 2'd3, 8'h19, 3'd7, 4'h0, 0, 7'h0, "R9 read before write");
    rd(2'd3, "R9 read after write");
    step(0, 0, 2'd0, 8'h0, 3'd6, 4'h1, 0, 7'h0, "");
    step(0, 0, 2'd0, 8'h0, 3'd7, 4'h0, 0, 7'h0, "");
    n_cmp++;
    if (cpu_rdata !== 8'h19) begin
      n_bad++;
      $display("FAIL R9 hold without read: got 0x%02h expected 0x19", cpu_rdata);
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule